// File: doc/BRIEF.md
# Compare Waveform Generator

This block sits beside an external timer counter and turns its count into per-channel waveforms and match indications. Each clock cycle it receives the counter value and a count-enable tick. Each channel has a compare register, and the block compares every register with the counter on each tick. A hit updates the channel's waveform, sets its sticky match flag and, if enabled, sends out a one-cycle event pulse. The block also reports the top value at which the external counter has to wrap. That value depends on the generation mode, so the counter logic can follow it.

There are four generation modes. The two frequency modes toggle an output on each match. The two PWM modes drive an output high from the counter's restart until the compare value, and low after that. The "normal" variants take the top from the period input when the counter is narrow, or use the full counter range when it is wide. The "match" variants use compare channel 0 as the top instead. Each channel has its own invert bit, applied at the output. Flags stay set until cleared by writing a one.

Top module: `cmp_wavegen`

## Requirements
- R1: After synchronous reset, all waveform outputs (before inversion), flags, interrupt requests and event pulses are 0, and all compare registers are 0.
- R2: A channel hit is a clock edge where `tick` is 1 and `cnt` equals that channel's compare register. The channel's flag is 1 from the cycle after a hit.
- R3: `irq[i]` is 1 exactly when `flag[i]` is 1 and `int_en[i]` is 1.
- R4: `evt[i]` is a one-cycle pulse in the cycle after a hit, and only when `evo_en[i]` was 1 at the hit.
- R5: In modes 0 (normal frequency) and 2 (normal PWM), `top_out` is `per_val` zero-extended when `narrow_mode` is 1, and all ones when it is 0.
- R6: In modes 1 (match frequency) and 3 (match PWM), `top_out` equals compare register 0.
- R7: In modes 0 and 1, each channel's waveform toggles on each of its hits.
- R8: In mode 2, a hit drives the waveform to 0. Otherwise, a tick with `cnt` equal to `top_out` drives it to 1. If both happen at once, the hit wins.
- R9: In mode 3, channel 0's waveform toggles on its hits, and every other channel follows the PWM rule of R8 against the top of R6.
- R10: `wo[i]` is the generated waveform XORed with `inv_en[i]`, and the invert takes effect in the same cycle it changes.
- R11: A 1 on `flag_clr[i]` clears the flag at that edge. If a hit happens at the same edge, the flag stays 1.
- R12: When `tick` is 0, no hit occurs: flags (unless cleared), waveforms and events do not change.
- R13: A write with `cc_wr_en[i]` loads `cc_wr_data` at that edge. The compare in that same cycle still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-enable tick; compares act only when 1 |
| cnt | input | CNT_W | Current counter value |
| per_val | input | PER_W | Period value used as top in narrow normal modes |
| narrow_mode | input | 1 | 1: counter is narrow (period-limited), 0: full width |
| wave_mode | input | 2 | 0 normal freq, 1 match freq, 2 normal PWM, 3 match PWM |
| cc_wr_en | input | NCH | Per-channel compare register write strobe |
| cc_wr_data | input | CNT_W | Compare write data |
| inv_en | input | NCH | Per-channel output invert |
| int_en | input | NCH | Per-channel interrupt enable |
| evo_en | input | NCH | Per-channel event output enable |
| flag_clr | input | NCH | Write-one-to-clear for the flags |
| top_out | output | CNT_W | Top value the counter must wrap at |
| wo | output | NCH | Waveform outputs after inversion |
| flag | output | NCH | Sticky match flags |
| irq | output | NCH | Interrupt requests |
| evt | output | NCH | Match event pulses |

## Verification
The bench builds the block with CNT_W=16, PER_W=8 and NCH=2. A small period keeps the narrow-mode wraps close together, so many wraps fit in a short run. For the full-width case, the bench loads the counter just below 65535, which reaches the all-ones top within a few ticks. With two channels, the bench exercises the split in the match modes: channel 0 sets the top and channel 1 follows it. Ticks arrive at random, and flag clears are scattered at random, so clears fall on hit cycles and idle stretches occur.

// File: rtl/wg_pkg.sv
package wg_pkg;
  typedef enum logic [1:0] {
    WG_NFRQ = 2'd0,
    WG_MFRQ = 2'd1,
    WG_NPWM = 2'd2,
    WG_MPWM = 2'd3
  } wg_mode_e;
endpackage

// File: rtl/wg_top_sel.sv
module wg_top_sel #(
  parameter int CNT_W = 16,
  parameter int PER_W = 8
) (
  input  wg_pkg::wg_mode_e  mode,
  input  logic              narrow,
  input  logic [PER_W-1:0]  per_val,
  input  logic [CNT_W-1:0]  cc_ref,
  output logic [CNT_W-1:0]  top
);
  localparam int PAD_W = CNT_W - PER_W;

  always_comb begin
    if (mode == wg_pkg::WG_MFRQ || mode == wg_pkg::WG_MPWM)
      top = cc_ref;
    else if (narrow)
      top = {{PAD_W{1'b0}}, per_val};
    else
      top = {CNT_W{1'b1}};
  end
endmodule

// File: rtl/wg_channel.sv
module wg_channel #(
  parameter int CNT_W  = 16,
  parameter bit IS_REF = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  wg_pkg::wg_mode_e mode,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] top,
  input  logic             cc_we,
  input  logic [CNT_W-1:0] cc_wd,
  input  logic             clr,
  input  logic             evo_en,
  output logic [CNT_W-1:0] cc_q,
  output logic             wave_q,
  output logic             flag_q,
  output logic             evt_q
);
  logic hit;
  logic at_top;
  logic use_pwm;
  logic wave_nx;

  assign hit    = tick && (cnt == cc_q);
  assign at_top = tick && (cnt == top);

  always_comb begin
    unique case (mode)
      wg_pkg::WG_NPWM: use_pwm = 1'b1;
      wg_pkg::WG_MPWM: use_pwm = !IS_REF;
      default:         use_pwm = 1'b0;
    endcase
  end

  always_comb begin
    wave_nx = wave_q;
    if (use_pwm) begin
      if (hit)         wave_nx = 1'b0;
      else if (at_top) wave_nx = 1'b1;
    end else if (hit) begin
      wave_nx = !wave_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cc_q   <= '0;
      wave_q <= 1'b0;
      flag_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      if (cc_we) cc_q <= cc_wd;
      wave_q <= wave_nx;
      flag_q <= (flag_q && !clr) || hit;
      evt_q  <= hit && evo_en;
    end
  end
endmodule

// File: rtl/cmp_wavegen.sv
module cmp_wavegen #(
  parameter int CNT_W = 16,
  parameter int PER_W = 8,
  parameter int NCH   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic [PER_W-1:0] per_val,
  input  logic             narrow_mode,
  input  logic [1:0]       wave_mode,
  input  logic [NCH-1:0]   cc_wr_en,
  input  logic [CNT_W-1:0] cc_wr_data,
  input  logic [NCH-1:0]   inv_en,
  input  logic [NCH-1:0]   int_en,
  input  logic [NCH-1:0]   evo_en,
  input  logic [NCH-1:0]   flag_clr,
  output logic [CNT_W-1:0] top_out,
  output logic [NCH-1:0]   wo,
  output logic [NCH-1:0]   flag,
  output logic [NCH-1:0]   irq,
  output logic [NCH-1:0]   evt
);
  wg_pkg::wg_mode_e mode;
  logic [CNT_W-1:0] cc_arr [NCH];
  logic [NCH-1:0]   wave_raw;

  assign mode = wg_pkg::wg_mode_e'(wave_mode);

  wg_top_sel #(.CNT_W(CNT_W), .PER_W(PER_W)) top_i (
    .mode(mode), .narrow(narrow_mode), .per_val(per_val),
    .cc_ref(cc_arr[0]), .top(top_out)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    wg_channel #(.CNT_W(CNT_W), .IS_REF(g == 0)) ch_i (
      .clk(clk), .rst(rst), .tick(tick), .mode(mode), .cnt(cnt),
      .top(top_out), .cc_we(cc_wr_en[g]), .cc_wd(cc_wr_data),
      .clr(flag_clr[g]), .evo_en(evo_en[g]), .cc_q(cc_arr[g]),
      .wave_q(wave_raw[g]), .flag_q(flag[g]), .evt_q(evt[g])
    );
  end

  assign wo  = wave_raw ^ inv_en;
  assign irq = flag & int_en;
endmodule

// File: rtl/cmp_wavegen_chk.sv
module cmp_wavegen_chk #(
  parameter int CNT_W = 16,
  parameter int NCH   = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic [1:0]       wave_mode,
  input logic [NCH-1:0]   cc_wr_en,
  input logic [CNT_W-1:0] cc_wr_data,
  input logic [NCH-1:0]   flag_clr,
  input logic [NCH-1:0]   evo_en,
  input logic [NCH-1:0]   flag,
  input logic [NCH-1:0]   evt,
  input logic [CNT_W-1:0] top_out
);
  for (genvar g = 0; g < NCH; g++) begin : g_a
    assert_flag_needs_tick_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(flag[g]) |-> $past(tick));
    assert_evt_gated_R4: assert property (@(posedge clk) disable iff (rst)
      evt[g] |-> $past(evo_en[g] && tick));
    assert_clear_works_R11: assert property (@(posedge clk) disable iff (rst)
      (flag_clr[g] && !tick) |=> !flag[g]);
    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
      (!tick && !flag_clr[g]) |=> $stable(flag[g]));
  end

  assert_match_top_R6: assert property (@(posedge clk) disable iff (rst)
    cc_wr_en[0] |=> (wave_mode != 2'd1 || top_out == $past(cc_wr_data)));
endmodule

bind cmp_wavegen cmp_wavegen_chk #(.CNT_W(CNT_W), .NCH(NCH)) chk_i (
  .clk(clk), .rst(rst), .tick(tick), .wave_mode(wave_mode),
  .cc_wr_en(cc_wr_en), .cc_wr_data(cc_wr_data), .flag_clr(flag_clr),
  .evo_en(evo_en), .flag(flag), .evt(evt), .top_out(top_out)
);

// File: tb/cmp_wavegen_tb_top.sv
module cmp_wavegen_tb_top;
  localparam int CNT_W = 16;
  localparam int PER_W = 8;
  localparam int NCH   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [CNT_W-1:0] cnt = '0;
  logic [PER_W-1:0] per_val = '0;
  logic narrow_mode = 1'b1;
  logic [1:0] wave_mode = 2'd0;
  logic [NCH-1:0] cc_wr_en = '0;
  logic [CNT_W-1:0] cc_wr_data = '0;
  logic [NCH-1:0] inv_en = '0, int_en = '0, evo_en = '0, flag_clr = '0;
  logic [CNT_W-1:0] top_out;
  logic [NCH-1:0] wo, flag, irq, evt;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int clr_pct = 0;

  always #2ns clk = !clk;

  cmp_wavegen #(.CNT_W(CNT_W), .PER_W(PER_W), .NCH(NCH)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .cnt(cnt), .per_val(per_val),
    .narrow_mode(narrow_mode), .wave_mode(wave_mode), .cc_wr_en(cc_wr_en),
    .cc_wr_data(cc_wr_data), .inv_en(inv_en), .int_en(int_en),
    .evo_en(evo_en), .flag_clr(flag_clr), .top_out(top_out), .wo(wo),
    .flag(flag), .irq(irq), .evt(evt)
  );

  // behavioural reference
  int m_cc [NCH];
  bit m_wave [NCH];
  bit m_flag [NCH];
  bit m_evt [NCH];

  function automatic int ref_top();
    if (wave_mode == 2'd1 || wave_mode == 2'd3) return m_cc[0];
    if (narrow_mode) return int'(per_val);
    return (1 << CNT_W) - 1;
  endfunction

  always @(posedge clk) begin
    int t;
    bit h [NCH];
    t = ref_top();
    for (int c = 0; c < NCH; c++) h[c] = tick && (int'(cnt) == m_cc[c]);
    for (int c = 0; c < NCH; c++) begin
      if (rst) begin
        m_cc[c] = 0; m_wave[c] = 0; m_flag[c] = 0; m_evt[c] = 0;
      end else begin
        bit pwm;
        pwm = (wave_mode == 2'd2) || (wave_mode == 2'd3 && c != 0);
        if (pwm) begin
          if (h[c]) m_wave[c] = 0;
          else if (tick && int'(cnt) == t) m_wave[c] = 1;
        end else if (h[c]) m_wave[c] = !m_wave[c];
        m_flag[c] = (m_flag[c] && !flag_clr[c]) || h[c];
        m_evt[c] = h[c] && evo_en[c];
        if (cc_wr_en[c]) m_cc[c] = int'(cc_wr_data);
      end
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    string wreq;
    case (wave_mode)
      2'd2:    wreq = "R8 R10 wo";
      2'd3:    wreq = "R9 R10 wo";
      default: wreq = "R7 R10 wo";
    endcase
    check((wave_mode[0]) ? "R6 top" : "R5 top", top_out, ref_top());
    for (int c = 0; c < NCH; c++) begin
      check(wreq, wo[c], m_wave[c] ^ inv_en[c]);
      check("R2 R11 R12 R13 flag", flag[c], m_flag[c]);
      check("R3 irq", irq[c], m_flag[c] && int_en[c]);
      check("R4 evt", evt[c], m_evt[c]);
    end
  endtask

  // one cycle: compare at negedge, then drive next inputs
  task automatic step(input int tick_pct);
    @(negedge clk);
    compare_all();
    if (tick) cnt = (int'(cnt) >= ref_top()) ? '0 : cnt + 1'b1;
    cc_wr_en = '0;
    tick = ($urandom % 100) < tick_pct;
    for (int c = 0; c < NCH; c++) flag_clr[c] = ($urandom % 100) < clr_pct;
  endtask

  task automatic run(input int n, input int tick_pct);
    for (int k = 0; k < n; k++) step(tick_pct);
  endtask

  task automatic write_cc(input int ch, input int val);
    @(negedge clk);
    compare_all();
    tick = 1'b0;
    cc_wr_en = '0;
    cc_wr_en[ch] = 1'b1;
    cc_wr_data = CNT_W'(val);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 wo", wo, 0);
    check("R1 flag", flag, 0);
    check("R1 irq", irq, 0);
    check("R1 evt", evt, 0);

    // normal frequency, narrow counter
    per_val = 8'd9; narrow_mode = 1'b1; wave_mode = 2'd0;
    int_en = 2'b01; evo_en = 2'b10; clr_pct = 10;
    write_cc(0, 3); write_cc(1, 7);
    run(200, 70);

    // normal frequency, full width: jump near all ones
    narrow_mode = 1'b0; write_cc(1, 65533);
    @(negedge clk); compare_all(); cc_wr_en = '0; cnt = 16'd65528;
    run(40, 80);

    // match frequency, channel 0 is top
    wave_mode = 2'd1; inv_en = 2'b10; int_en = 2'b11; evo_en = 2'b11;
    cnt = '0; write_cc(0, 5); write_cc(1, 2);
    run(120, 70);

    // normal PWM, compare equal to top on channel 1
    wave_mode = 2'd2; narrow_mode = 1'b1; per_val = 8'd7; inv_en = 2'b01;
    cnt = '0; write_cc(0, 2); write_cc(1, 7);
    run(150, 75);

    // match PWM
    wave_mode = 2'd3; inv_en = 2'b11; clr_pct = 25;
    cnt = '0; write_cc(0, 6); write_cc(1, 3);
    run(150, 70);

    // R12: no ticks, only clears
    run(30, 0);

    // R13: write while counter sits on old value with tick high
    @(negedge clk); compare_all();
    cnt = 16'd3; tick = 1'b1; flag_clr = '0;
    cc_wr_en = 2'b10; cc_wr_data = 16'd4;
    @(negedge clk); compare_all();
    cc_wr_en = '0; tick = 1'b0;
    // R11: clear coinciding with a hit keeps flag set
    cnt = 16'd4; tick = 1'b1; flag_clr = 2'b10;
    @(negedge clk); compare_all();
    check("R11 clear vs hit", flag[1], 1);
    tick = 1'b0; flag_clr = 2'b10;
    @(negedge clk); compare_all();
    flag_clr = '0;
    run(20, 60);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4ns * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule